// File: doc/BRIEF.md
# Register-Immediate Integer Execute Slice

This block is a compact execute stage for a 32-bit load-store instruction word. It holds its own bank of thirty-two 32-bit general registers. In each cycle it may accept one instruction word, qualified by a valid strobe. It decodes three operations: a register-plus-register add, an add of a sign-extended 16-bit constant, and a load of a 16-bit constant into the upper half of a register. It reads the source registers combinationally, forms the sum or the shifted constant, and writes the destination on the next rising clock edge. A 32-bit constant therefore takes two instructions: an upper load, then an add-immediate of the signed low half.

A small controller remembers what the previous accepted cycle did. It has three states:

- `ST_IDLE`: nothing was accepted.
- `ST_COMMIT`: a legal instruction retired.
- `ST_FAULT`: an unsupported encoding arrived.

On every clock the controller moves to one of these states. It goes to `ST_COMMIT` on a valid legal word, to `ST_FAULT` on a valid unsupported word, and to `ST_IDLE` when no word is valid. The next state does not depend on the current state. The write-back observation port and the illegal flag are decoded from the current state. Reset is synchronous and returns the controller to `ST_IDLE`.

Top module: `rimm_exec_slice`

## Requirements
- R1: With opcode (bits 31..26) equal to 0 and function code (bits 5..0) equal to 32, the block writes rs (bits 25..21) + rt (bits 20..16) into rd (bits 15..11).
- R2: Opcode 8 adds the 16-bit field in bits 15..0, sign-extended (range -32768..32767), to rs and writes the sum into rt.
- R3: Opcode 15 writes the 16-bit field into bits 31..16 of rt and zeroes bits 15..0. The rs field has no effect on this operation.
- R4: Sums wrap modulo 2^32, and overflow raises no flag.
- R5: Register 0 always reads as zero. A write aimed at register 0 is discarded, although it still retires.
- R6: A valid legal word presented in cycle N is written at the edge that ends cycle N. During cycle N+1, wb_valid is high, and wb_dest and wb_value show the destination and the result. Consequently, back-to-back dependent instructions see the new value.
- R7: A valid word with any other opcode, or with opcode 0 and any function code other than 32, raises illegal for exactly one cycle (N+1). It writes no register and keeps wb_valid low.
- R8: When instr_valid is low, the instruction word is ignored: no register changes and neither output strobe rises.
- R9: A synchronous reset clears every register to zero and drives wb_valid and illegal low.
- R10: An upper load of 61 followed by an add-immediate of 2304 on the same register yields 0x003D0900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies instr_word for this cycle |
| instr_word | input | 32 | Instruction to execute |
| wb_valid | output | 1 | A legal instruction retired at the last edge |
| wb_dest | output | 5 | Destination register of the retired instruction |
| wb_value | output | 32 | Result of the retired instruction |
| illegal | output | 1 | An unsupported encoding arrived at the last edge |

## Verification
The arithmetic is tried with several kinds of operand:

- Small positive and negative constants show whether sign extension of the immediate is correct.
- The extreme constants 32767 and -32768 show whether the sign extension is done at bit 15.
- Sums that pass 2^32 show whether results wrap instead of saturating.

Back-to-back dependent words, with the upper load followed by the add of 2304, tell whether the write lands before the next read. A garbage rs field on the upper load shows whether rs is truly ignored.

For the fault and no-effect cases, the bench reads a register back after the stimulus. This covers unknown opcodes, a wrong function code, a word whose valid strobe is low, writes aimed at register 0, and a mid-run reset. Each case tells a discarded write apart from one that leaked into the register bank.

// File: rtl/rimm_pkg.sv
package rimm_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned RIDX_W  = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned FN_W    = 6;

    // field positions are fixed by the encoding
    localparam int unsigned OPC_LSB = 26;
    localparam int unsigned RS_LSB  = 21;
    localparam int unsigned RT_LSB  = 16;
    localparam int unsigned RD_LSB  = 11;
    localparam int unsigned FN_LSB  = 0;
    localparam int unsigned IMM_LSB = 0;

    localparam logic [OPC_W-1:0] OPC_REGREG = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI   = 6'd8;
    localparam logic [OPC_W-1:0] OPC_LUI    = 6'd15;
    localparam logic [FN_W-1:0]  FN_ADD     = 6'd32;

    typedef enum logic [1:0] {
        ALU_ADD_RR  = 2'd0,
        ALU_ADD_IMM = 2'd1,
        ALU_UPPER   = 2'd2
    } alu_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FAULT  = 2'd2
    } exec_state_e;

    typedef struct packed {
        logic              legal;
        alu_sel_e          sel;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] dst;
        logic [IMM_W-1:0]  imm;
    } dec_t;

endpackage

// File: rtl/rimm_decode.sv
module rimm_decode
    import rimm_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output dec_t              dec
);

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic [RIDX_W-1:0] f_rs;
    logic [RIDX_W-1:0] f_rt;
    logic [RIDX_W-1:0] f_rd;
    logic [IMM_W-1:0]  f_imm;

    always_comb begin
        opc   = word[OPC_LSB +: OPC_W];
        fn    = word[FN_LSB  +: FN_W];
        f_rs  = word[RS_LSB  +: RIDX_W];
        f_rt  = word[RT_LSB  +: RIDX_W];
        f_rd  = word[RD_LSB  +: RIDX_W];
        f_imm = word[IMM_LSB +: IMM_W];
    end

    always_comb begin
        dec.legal = 1'b0;
        dec.sel   = ALU_ADD_RR;
        dec.rs    = f_rs;
        dec.rt    = f_rt;
        dec.dst   = f_rd;
        dec.imm   = f_imm;
        unique case (opc)
            OPC_REGREG: begin
                // R1 / R7: only the add function code is supported
                dec.legal = (fn == FN_ADD);
                dec.sel   = ALU_ADD_RR;
                dec.dst   = f_rd;
            end
            OPC_ADDI: begin
                dec.legal = 1'b1;
                dec.sel   = ALU_ADD_IMM;
                dec.dst   = f_rt;
            end
            OPC_LUI: begin
                dec.legal = 1'b1;
                dec.sel   = ALU_UPPER;
                dec.dst   = f_rt;
            end
            default: begin
                dec.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rimm_regfile.sv
module rimm_regfile #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(DEPTH)-1:0]  ra_addr,
    output logic [DATA_W-1:0]         ra_data,
    input  logic [$clog2(DEPTH)-1:0]  rb_addr,
    output logic [DATA_W-1:0]         rb_data,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic [DATA_W-1:0] bank_q [DEPTH];
    logic              wr_ok;

    assign wr_ok = wr_en && (wr_addr != ZERO_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
            end
        end else if (wr_ok) begin
            bank_q[wr_addr] <= wr_data;
        end
    end

    // R5: entry zero is read as zero regardless of its storage
    always_comb begin
        ra_data = (ra_addr == ZERO_IDX) ? '0 : bank_q[ra_addr];
        rb_data = (rb_addr == ZERO_IDX) ? '0 : bank_q[rb_addr];
    end

    logic any_set;
    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            any_set = any_set | (|bank_q[i]);
        end
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !any_set);

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != ZERO_IDX) |=> bank_q[$past(wr_addr)] == $past(wr_data));

    // R5
    zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bank_q[0] == '0);

endmodule

// File: rtl/rimm_alu.sv
module rimm_alu
    import rimm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  alu_sel_e          sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] res
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_hi;
    logic [DATA_W-1:0] addend;

    always_comb begin
        imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_hi = {imm, {EXT_W{1'b0}}};
        addend = (sel == ALU_ADD_IMM) ? imm_sx : op_b;
    end

    // R4: plain modular add, carry out dropped
    always_comb begin
        unique case (sel)
            ALU_ADD_RR,
            ALU_ADD_IMM: res = op_a + addend;
            ALU_UPPER:   res = imm_hi;
            default:     res = '0;
        endcase
    end

endmodule

// File: rtl/rimm_exec_slice.sv
module rimm_exec_slice
    import rimm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              wb_valid,
    output logic [4:0]        wb_dest,
    output logic [DATA_W-1:0] wb_value,
    output logic              illegal
);

    localparam int unsigned NREGS = 1 << RIDX_W;

    dec_t              dec;
    logic [DATA_W-1:0] rs_val;
    logic [DATA_W-1:0] rt_val;
    logic [DATA_W-1:0] result;
    logic              commit;
    exec_state_e       state_q;
    exec_state_e       state_d;

    rimm_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    rimm_regfile #(
        .DATA_W (DATA_W),
        .DEPTH  (NREGS)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (dec.rs),
        .ra_data (rs_val),
        .rb_addr (dec.rt),
        .rb_data (rt_val),
        .wr_en   (commit),
        .wr_addr (dec.dst),
        .wr_data (result)
    );

    rimm_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .sel  (dec.sel),
        .op_a (rs_val),
        .op_b (rt_val),
        .imm  (dec.imm),
        .res  (result)
    );

    assign commit = instr_valid && dec.legal;

    // next state follows only this cycle's input
    always_comb begin
        state_d = ST_IDLE;
        if (instr_valid) begin
            state_d = dec.legal ? ST_COMMIT : ST_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_dest  <= '0;
            wb_value <= '0;
        end else if (commit) begin
            wb_dest  <= dec.dst;
            wb_value <= result;
        end
    end

    always_comb begin
        wb_valid = 1'b0;
        illegal  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: wb_valid = 1'b1;
            ST_FAULT:  illegal  = 1'b1;
            default:   ;
        endcase
    end

    // R6
    wb_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(instr_valid));

    // R7
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wb_valid && $past(instr_valid)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!wb_valid && !illegal));

endmodule

// File: tb/rimm_exec_slice_test.sv
`timescale 1ns/1ps
module rimm_exec_slice_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        wb_valid;
    logic [4:0]  wb_dest;
    logic [31:0] wb_value;
    logic        illegal;

    always #2.5 clk = ~clk;

    rimm_exec_slice uut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .wb_valid    (wb_valid),
        .wb_dest     (wb_dest),
        .wb_value    (wb_value),
        .illegal     (illegal)
    );

    typedef struct {
        int          stamp;
        bit          exp_wb;
        bit          exp_ill;
        logic [4:0]  dest;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    task automatic step(input bit v, input logic [31:0] w, input bit ewb, input bit eill,
                        input int dest, input logic [31:0] val, input string tag);
        item_t it;
        instr_valid = v;
        instr_word  = w;
        it.stamp   = cyc;
        it.exp_wb  = ewb;
        it.exp_ill = eill;
        it.dest    = 5'(dest);
        it.val     = val;
        it.tag     = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor: compare every cycle's outcome one edge after issue
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].stamp < cyc) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (wb_valid !== it.exp_wb || illegal !== it.exp_ill ||
                    (it.exp_wb && (wb_dest !== it.dest || wb_value !== it.val))) begin
                    fails++;
                    $display("FAIL %s: got wb=%b ill=%b dest=%0d val=%h, expected wb=%b ill=%b dest=%0d val=%h",
                             it.tag, wb_valid, illegal, wb_dest, wb_value,
                             it.exp_wb, it.exp_ill, it.dest, it.val);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet while in reset
        checks++;
        if (wb_valid !== 1'b0 || illegal !== 1'b0) begin
            fails++;
            $display("FAIL R9: got wb=%b ill=%b, expected 0 0", wb_valid, illegal);
        end
        rst = 1'b0;
        // R9: registers read zero after reset
        step(1, enc_r(5, 6, 9, 32), 1, 0, 9, 32'h0, "R9 reg clear");
        // R3: upper load, garbage rs field
        step(1, enc_i(15, 7, 1, 16'd61), 1, 0, 1, 32'h003D0000, "R3 upper load");
        // R10 / R6: dependent add of low half
        step(1, enc_i(8, 1, 1, 16'd2304), 1, 0, 1, 32'h003D0900, "R10 two-step const");
        // R2: sign extension
        step(1, enc_i(8, 0, 2, 16'hFFF8), 1, 0, 2, 32'hFFFFFFF8, "R2 negative imm");
        step(1, enc_i(8, 0, 3, 16'h7FFF), 1, 0, 3, 32'h00007FFF, "R2 max imm");
        step(1, enc_i(8, 0, 4, 16'h8000), 1, 0, 4, 32'hFFFF8000, "R2 min imm");
        // R1: register add
        step(1, enc_r(1, 2, 5, 32), 1, 0, 5, 32'h003D08F8, "R1 reg add");
        // R4: wrap
        step(1, enc_i(15, 0, 6, 16'hFFFF), 1, 0, 6, 32'hFFFF0000, "R3 upper all ones");
        step(1, enc_r(6, 6, 7, 32), 1, 0, 7, 32'hFFFE0000, "R4 wrap reg add");
        step(1, enc_i(8, 2, 8, 16'd16), 1, 0, 8, 32'h00000008, "R4 wrap imm add");
        // R5: write to register 0 discarded
        step(1, enc_r(1, 1, 0, 32), 1, 0, 0, 32'h007A1200, "R5 write r0 retires");
        step(1, enc_r(0, 0, 9, 32), 1, 0, 9, 32'h0, "R5 r0 still zero");
        // R7: unknown opcode, then prove rt untouched
        step(1, enc_i(35, 0, 3, 16'h1234), 0, 1, 0, 32'h0, "R7 bad opcode");
        step(1, enc_r(3, 0, 10, 32), 1, 0, 10, 32'h00007FFF, "R7 rt unchanged");
        // R7: wrong function code
        step(1, enc_r(1, 1, 4, 33), 0, 1, 0, 32'h0, "R7 bad funct");
        step(1, enc_r(4, 0, 11, 32), 1, 0, 11, 32'hFFFF8000, "R7 rd unchanged");
        // R8: word with valid low ignored
        step(0, enc_i(8, 0, 3, 16'd1), 0, 0, 0, 32'h0, "R8 invalid word");
        step(0, 32'h0, 0, 0, 0, 32'h0, "R8 idle");
        step(1, enc_r(3, 0, 12, 32), 1, 0, 12, 32'h00007FFF, "R8 reg unchanged");
        // R1: literal encoding of add 8,17,18
        step(1, enc_i(8, 0, 17, 16'd100), 1, 0, 17, 32'd100, "R2 set r17");
        step(1, enc_i(8, 0, 18, 16'd23), 1, 0, 18, 32'd23, "R2 set r18");
        step(1, 32'b000000_10001_10010_01000_00000_100000, 1, 0, 8, 32'd123, "R1 literal word");
        // R9: mid-run reset
        rst = 1'b1;
        step(1, enc_i(8, 0, 13, 16'd5), 0, 0, 0, 32'h0, "R9 reset cycle");
        rst = 1'b0;
        step(1, enc_r(1, 8, 14, 32), 1, 0, 14, 32'h0, "R9 regs cleared");
        step(0, 32'h0, 0, 0, 0, 32'h0, "R8 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule